// File: doc/BRIEF.md
# Four-Channel Bus-Master Transfer Controller

This block moves data on behalf of up to four peripherals without processor involvement. Software first sets each channel's start address and its transfer count, and then enables the channels it wants through a shared enable register. The transfer count register holds the number of transfers minus one in its low bits, and the transfer kind in its top two bits. When an enabled peripheral raises its request line, the controller asks the host for the bus. Once the host grants the bus, the controller runs single-cycle transfers. On each transfer it drives the channel's address and a per-channel acknowledge, steps the address, and counts down.

When a channel's count runs out, the controller does three things: it pulses a terminal-count output, it latches a per-channel completion flag, and it disables that channel. When no enabled request remains, the controller releases the bus. Reading the completion flags clears them. Verify transfers walk through the address range without asserting either memory strobe. The fourth kind code is illegal and never starts a transfer.

Top module: `quad_dma_ctrl`

## Requirements
- R1: After synchronous reset, `hold`, `dack`, `mem_rd`, `mem_wr`, `tc_pulse` and `bus_addr` are zero, and every register reads as zero.
- R2: Register select values 0 to 3 address the channel 0 to 3 address registers. Values 4 to 7 address the channel 0 to 3 count registers. Value 8 is the enable register (bits 3:0, bit n enables channel n). Value 9 is the completion register (bits 3:0, bit n for channel n). Writes load the full 16 bits, and reads return them combinationally. Any other select reads zero.
- R3: A channel is pending when its request is high, its enable bit is set, and its kind is not illegal. In the cycle after a pending request is seen, `hold` rises. No transfer happens until `hlda` is high. In a cycle where `hlda` is high but nothing is pending, the controller drops `hold` on the next edge.
- R4: A transfer lasts one cycle. During it, exactly one `dack` bit (the serviced channel) is high, and `bus_addr` carries that channel's address. Two transfers are always separated by at least one cycle.
- R5: Count bits 15:14 give the transfer kind. 01 asserts `mem_wr` and 10 asserts `mem_rd` during the transfer. 00 (verify) asserts neither strobe, but it still steps the address and the count.
- R6: A channel whose count bits 15:14 are 11 is never acknowledged, and its registers stay unchanged.
- R7: After each transfer, the channel's address register increases by one, wrapping from 0xFFFF to 0x0000.
- R8: After each transfer, count bits 13:0 decrease by one and bits 15:14 are kept, so a loaded value of N-1 yields exactly N transfers.
- R9: A transfer issued while count bits 13:0 are zero is the terminal one. `tc_pulse` is high during that transfer. On the following edge, the channel's completion bit is set and its enable bit is cleared.
- R10: When several channels are pending at arbitration, the lowest-numbered one is serviced first.
- R11: A cycle with `cfg_rd` high and select 9 clears the completion register at its end. A flag set on the same edge survives.
- R12: A request on a channel whose enable bit is clear has no effect: `hold` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 4 | Register select |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (clears completion flags at select 9) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| dreq | input | 4 | Per-channel transfer requests |
| hlda | input | 1 | Bus grant from the host |
| hold | output | 1 | Bus request to the host |
| dack | output | 4 | Per-channel transfer acknowledge |
| bus_addr | output | 16 | Transfer address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| tc_pulse | output | 1 | Terminal-transfer indication |

## Verification
The bench builds the controller with its default four channels and 16-bit registers. This makes the exact count-register layout reachable, including the kind bits at 15:14 and the 14-bit count field. It also lets one run cover all four kind codes side by side and pit three channels against each other in arbitration. The 16-bit width means a channel started at 0xFFFF shows the address wrap within two transfers. Short counts (two and three transfers) bring the terminal transfer, the automatic disable and the flag clear on read within a few dozen cycles.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

    // Transfer kind carried in the two top bits of a count register
    typedef enum logic [1:0] {
        XK_VERIFY  = 2'b00,
        XK_WRITE   = 2'b01,
        XK_READ    = 2'b10,
        XK_ILLEGAL = 2'b11
    } xfer_kind_e;

    // Bus sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_MOVE = 2'd2
    } seq_state_e;

    // Per-cycle bus beat description
    typedef struct packed {
        logic active;
        logic rd;
        logic wr;
        logic tc;
    } bus_beat_t;

    function automatic xfer_kind_e kind_of(input logic [1:0] bits);
        return xfer_kind_e'(bits);
    endfunction

    function automatic logic kind_ok(input xfer_kind_e k);
        return k != XK_ILLEGAL;
    endfunction

endpackage

// File: rtl/qdma_chan.sv
module qdma_chan
    import qdma_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_addr,
    input  logic         ld_cnt,
    input  logic         step,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] addr_o,
    output logic [W-1:0] cnt_o,
    output xfer_kind_e   kind_o,
    output logic         last_o
);
    localparam int LW = W - 2;   // width of the count field

    logic [W-1:0] addr_q;
    logic [W-1:0] cnt_q;

    // a running transfer takes precedence over a software load
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (step)         addr_q <= addr_q + 1'b1;
            else if (ld_addr) addr_q <= wdata;

            if (step)         cnt_q <= {cnt_q[W-1:LW], cnt_q[LW-1:0] - 1'b1};
            else if (ld_cnt)  cnt_q <= wdata;
        end
    end

    assign addr_o = addr_q;
    assign cnt_o  = cnt_q;
    assign kind_o = kind_of(cnt_q[W-1:LW]);
    assign last_o = (cnt_q[LW-1:0] == '0);

    p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
        step |=> addr_q == W'($past(addr_q) + 1'b1));

    p_kind_kept_r8: assert property (@(posedge clk) disable iff (rst)
        step |=> cnt_q[W-1:LW] == $past(cnt_q[W-1:LW]));

    p_count_down_r8: assert property (@(posedge clk) disable iff (rst)
        step |=> cnt_q[LW-1:0] == LW'($past(cnt_q[LW-1:0]) - 1'b1));

endmodule

// File: rtl/qdma_prio.sv
module qdma_prio #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    // scan from the top so the lowest set index is the last to win
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/qdma_seq.sv
module qdma_seq
    import qdma_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  pend,
    input  logic          hlda,
    output logic          hold,
    output logic          move,
    output logic [IW-1:0] ch
);
    seq_state_e    state_q;
    logic [IW-1:0] pick;
    logic          any_pend;

    qdma_prio #(.N(N)) u_prio (
        .req (pend),
        .idx (pick),
        .any (any_pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            ch      <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (any_pend) state_q <= SQ_WAIT;
                SQ_WAIT: begin
                    if (hlda) begin
                        if (any_pend) begin
                            state_q <= SQ_MOVE;
                            ch      <= pick;
                        end else begin
                            state_q <= SQ_IDLE;
                        end
                    end
                end
                SQ_MOVE: state_q <= SQ_WAIT;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign hold = (state_q != SQ_IDLE);
    assign move = (state_q == SQ_MOVE);

    p_move_needs_grant_r3: assert property (@(posedge clk) disable iff (rst)
        move |-> $past(hlda) && $past(hold));

    p_release_when_empty_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_WAIT && hlda && !any_pend) |=> !hold);

    p_gap_between_moves_r4: assert property (@(posedge clk) disable iff (rst)
        move |=> !move);

    p_lowest_first_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_WAIT && hlda && pend[0]) |=> (move && ch == '0));

endmodule

// File: rtl/quad_dma_ctrl.sv
module quad_dma_ctrl
    import qdma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int W   = 16,
    localparam int RSW = $clog2(2 * NCH + 2)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [RSW-1:0] cfg_sel,
    input  logic           cfg_wr,
    input  logic           cfg_rd,
    input  logic [W-1:0]   cfg_wdata,
    output logic [W-1:0]   cfg_rdata,
    input  logic [NCH-1:0] dreq,
    input  logic           hlda,
    output logic           hold,
    output logic [NCH-1:0] dack,
    output logic [W-1:0]   bus_addr,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           tc_pulse
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [RSW-1:0] SEL_MODE = RSW'(2 * NCH);
    localparam logic [RSW-1:0] SEL_STAT = RSW'(2 * NCH + 1);

    logic [W-1:0]   addr_a [NCH];
    logic [W-1:0]   cnt_a  [NCH];
    xfer_kind_e     kind_a [NCH];
    logic [NCH-1:0] last_v;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] mode_q, mode_nx;
    logic [NCH-1:0] stat_q, stat_nx;
    logic           move;
    logic [CHW-1:0] ch;
    bus_beat_t      beat;

    // ---------------- channel register pairs ----------------
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        qdma_chan #(.W(W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .ld_addr (cfg_wr && cfg_sel == RSW'(g)),
            .ld_cnt  (cfg_wr && cfg_sel == RSW'(NCH + g)),
            .step    (move && ch == CHW'(g)),
            .wdata   (cfg_wdata),
            .addr_o  (addr_a[g]),
            .cnt_o   (cnt_a[g]),
            .kind_o  (kind_a[g]),
            .last_o  (last_v[g])
        );
        assign pend[g] = dreq[g] && mode_q[g] && kind_ok(kind_a[g]);
    end

    // ---------------- bus sequencer ----------------
    qdma_seq #(.N(NCH)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .pend (pend),
        .hlda (hlda),
        .hold (hold),
        .move (move),
        .ch   (ch)
    );

    always_comb begin
        beat.active = move;
        beat.rd     = move && (kind_a[ch] == XK_READ);
        beat.wr     = move && (kind_a[ch] == XK_WRITE);
        beat.tc     = move && last_v[ch];
    end

    always_comb begin
        dack = '0;
        if (beat.active) dack[ch] = 1'b1;
    end

    assign bus_addr = beat.active ? addr_a[ch] : '0;
    assign mem_rd   = beat.rd;
    assign mem_wr   = beat.wr;
    assign tc_pulse = beat.tc;

    // ---------------- shared enable and completion registers ----------------
    always_comb begin
        mode_nx = mode_q;
        if (cfg_wr && cfg_sel == SEL_MODE) mode_nx = cfg_wdata[NCH-1:0];
        if (beat.tc) mode_nx[ch] = 1'b0;

        stat_nx = stat_q;
        if (cfg_rd && cfg_sel == SEL_STAT) stat_nx = '0;
        if (beat.tc) stat_nx[ch] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            stat_q <= '0;
        end else begin
            mode_q <= mode_nx;
            stat_q <= stat_nx;
        end
    end

    // ---------------- register read mux ----------------
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (cfg_sel == RSW'(i))       cfg_rdata = addr_a[i];
            if (cfg_sel == RSW'(NCH + i)) cfg_rdata = cnt_a[i];
        end
        if (cfg_sel == SEL_MODE) cfg_rdata[NCH-1:0] = mode_q;
        if (cfg_sel == SEL_STAT) cfg_rdata[NCH-1:0] = stat_q;
    end

    // ---------------- assertions ----------------
    p_single_dack_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    p_dack_under_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (|dack) |-> hold);

    p_strobe_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_strobe_needs_dack_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> (|dack));

    p_tc_sets_flag_r9: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> stat_q[$past(ch)]);

    p_tc_disables_r9: assert property (@(posedge clk) disable iff (rst)
        (tc_pulse && !(cfg_wr && cfg_sel == SEL_MODE)) |=> !mode_q[$past(ch)]);

    p_status_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && cfg_sel == SEL_STAT && !tc_pulse) |=> stat_q == '0);

    p_disabled_no_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!hold && mode_q == '0 && !(cfg_wr && cfg_sel == SEL_MODE)) |=> !hold);

endmodule

// File: tb/sim_quad_dma_ctrl.sv
module sim_quad_dma_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int W   = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_sel = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [15:0] cfg_wdata = '0;
    wire  [15:0] cfg_rdata;
    logic [3:0]  dreq = '0;
    logic        hlda = 1'b0;
    wire         hold;
    wire  [3:0]  dack;
    wire  [15:0] bus_addr;
    wire         mem_rd, mem_wr, tc_pulse;

    quad_dma_ctrl #(.NCH(NCH), .W(W)) u0 (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq), .hlda(hlda),
        .hold(hold), .dack(dack), .bus_addr(bus_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .tc_pulse(tc_pulse)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_addr [4];
    int m_cnt  [4];
    int m_mode, m_stat, m_state, m_ch;

    always @(posedge clk) begin : ref_model
        int pend, o_state, o_ch, sel;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin m_addr[i] = 0; m_cnt[i] = 0; end
            m_mode = 0; m_stat = 0; m_state = 0; m_ch = 0;
        end else begin
            pend = 0;
            for (int i = 0; i < 4; i++)
                if (dreq[i] && m_mode[i] && (((m_cnt[i] >> 14) & 3) != 3)) pend |= (1 << i);
            o_state = m_state;
            o_ch = m_ch;
            sel = int'(cfg_sel);
            if (cfg_rd && sel == 9) m_stat = 0;
            if (cfg_wr) begin
                if (sel < 4 && !(o_state == 2 && o_ch == sel)) m_addr[sel] = int'(cfg_wdata);
                else if (sel >= 4 && sel < 8 && !(o_state == 2 && o_ch == sel - 4)) m_cnt[sel-4] = int'(cfg_wdata);
                else if (sel == 8) m_mode = int'(cfg_wdata) & 15;
            end
            if (o_state == 2) begin
                if ((m_cnt[o_ch] & 16'h3fff) == 0) begin
                    m_stat |= (1 << o_ch);
                    m_mode &= ~(1 << o_ch);
                end
                m_addr[o_ch] = (m_addr[o_ch] + 1) & 16'hffff;
                m_cnt[o_ch]  = (m_cnt[o_ch] & 16'hc000) | ((m_cnt[o_ch] - 1) & 16'h3fff);
            end
            case (o_state)
                0: if (pend != 0) m_state = 1;
                1: if (hlda) begin
                       if (pend != 0) begin
                           m_state = 2;
                           for (int i = 3; i >= 0; i--) if (pend[i]) m_ch = i;
                       end else m_state = 0;
                   end
                default: m_state = 1;
            endcase
        end
    end

    // ---------------- per-cycle comparison, away from the active edge ----------------
    int n_dack1 = 0, n_dack3 = 0, first_ch = -1;

    always @(negedge clk) begin
        if (!rst) begin
            int kind;
            bit mv;
            mv = (m_state == 2);
            kind = (m_cnt[m_ch] >> 14) & 3;
            chk("R3 hold", int'(hold), int'(m_state != 0));
            chk("R4 dack", int'(dack), mv ? (1 << m_ch) : 0);
            chk("R4 bus_addr", int'(bus_addr), mv ? m_addr[m_ch] : 0);
            chk("R5 mem_rd", int'(mem_rd), int'(mv && kind == 2));
            chk("R5 mem_wr", int'(mem_wr), int'(mv && kind == 1));
            chk("R9 tc_pulse", int'(tc_pulse), int'(mv && (m_cnt[m_ch] & 16'h3fff) == 0));
            if (dack[1]) n_dack1++;
            if (dack[3]) n_dack3++;
            if (dack != 0 && first_ch < 0)
                for (int i = 3; i >= 0; i--) if (dack[i]) first_ch = i;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        cfg_sel = 4'(sel); cfg_wdata = 16'(data); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input int sel, input string req, input int exp, input bit clr);
        @(negedge clk);
        cfg_sel = 4'(sel); cfg_rd = clr;
        #1;
        chk(req, int'(cfg_rdata), exp);
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R3 actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        cyc(3);
        rst = 1'b0;
        // R1: reset state
        #1;
        chk("R1 hold", int'(hold), 0);
        chk("R1 dack", int'(dack), 0);
        chk("R1 strobes", int'({mem_rd, mem_wr, tc_pulse}), 0);
        chk("R1 bus_addr", int'(bus_addr), 0);
        for (int s = 0; s < 10; s++) rd(s, "R1 register zero", 0, 1'b0);

        // R2: register map readback
        wr(1, 16'h1000);
        wr(5, 16'h4002);             // write kind, three transfers
        wr(8, 16'h0002);
        rd(1, "R2 ch1 address", 16'h1000, 1'b0);
        rd(5, "R2 ch1 count", 16'h4002, 1'b0);
        rd(8, "R2 enable", 16'h0002, 1'b0);
        rd(12, "R2 unused select", 0, 1'b0);

        // R3: hold without grant, no transfer
        dreq = 4'b0010;
        cyc(4);
        chk("R3 hold before grant", int'(hold), 1);
        chk("R3 no dack before grant", n_dack1, 0);
        hlda = 1'b1;
        cyc(12);
        dreq = '0;
        hlda = 1'b0;
        cyc(2);
        chk("R3 hold released", int'(hold), 0);
        chk("R8 ch1 transfer count", n_dack1, 3);
        rd(1, "R7 ch1 address stepped", 16'h1003, 1'b0);
        rd(5, "R8 ch1 count wrapped", 16'h7fff, 1'b0);
        rd(8, "R9 enable cleared", 0, 1'b0);
        rd(9, "R9 flag set", 16'h0002, 1'b1);
        rd(9, "R11 flag cleared by read", 0, 1'b0);

        // R5/R6/R7/R10: verify, read with wrap, illegal kind, priority
        first_ch = -1;
        wr(0, 16'h0200); wr(4, 16'h0001);   // verify, two transfers
        wr(2, 16'hffff); wr(6, 16'h8001);   // read, two transfers
        wr(3, 16'h3000); wr(7, 16'hc005);   // illegal kind
        wr(8, 16'h000f);
        dreq = 4'b1101;
        hlda = 1'b1;
        cyc(25);
        chk("R10 lowest channel first", first_ch, 0);
        chk("R6 illegal never acknowledged", n_dack3, 0);
        chk("R3 hold released with only illegal", int'(hold), 0);
        dreq = '0;
        hlda = 1'b0;
        rd(0, "R5 verify still steps address", 16'h0202, 1'b0);
        rd(4, "R5 verify still steps count", 16'h3fff, 1'b0);
        rd(2, "R7 address wrap", 16'h0001, 1'b0);
        rd(6, "R8 read count wrapped", 16'hbfff, 1'b0);
        rd(3, "R6 illegal address unchanged", 16'h3000, 1'b0);
        rd(7, "R6 illegal count unchanged", 16'hc005, 1'b0);
        rd(8, "R9 enables after terminals", 16'h000a, 1'b0);
        rd(9, "R9 flags ch0 and ch2", 16'h0005, 1'b1);

        // R12: disabled channels ignored
        wr(0, 16'h0500); wr(4, 16'h4003);
        wr(8, 16'h0000);
        dreq = 4'b1111;
        hlda = 1'b1;
        cyc(6);
        chk("R12 no hold when disabled", int'(hold), 0);
        dreq = '0;
        hlda = 1'b0;
        rd(0, "R12 disabled address unchanged", 16'h0500, 1'b0);
        cyc(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule